// File: doc/BRIEF.md
# UART character framer

This block is the character engine of a serial port. A transmit path takes one byte at a time over a valid/ready handshake and sends it as an asynchronous frame: a low start bit, the data bits starting with the least significant, an optional parity bit, and one or two high stop bits. A receive path watches the serial input, finds start bits, samples each bit in its middle, and hands back each character with a parity-error flag and a framing-error flag. Bit timing comes from `tick16`, an enable pulse at sixteen times the bit rate that a baud generator outside the block provides. FIFOs, baud generation and register access are also outside the block.

The 10-bit `mode_word` sets the frame format and routes the serial lines. It selects the character length, the parity scheme, the stop-bit count, and one of four channel modes: normal, automatic echo, local loopback and remote loopback. The 6-bit `ctrl_word` has a separate enable bit and disable bit for each direction, plus strobes that start and stop a break. `mode_word` is expected to stay stable while a character is in flight. `rxd` is resynchronised inside the block before the receiver uses it.

Top module: `uart_framer`

## Requirements
- R1: `mode_word[2:1]` sets the character length: 2'b10 gives 7 bits, 2'b11 gives 6 bits, and any other value gives 8 bits. Data goes onto the line least significant bit first. Transmit data bits above the length are ignored. Received data bits above the length read as zero.
- R2: `mode_word[5:3]` sets parity: 3'b000 even, 3'b001 odd, 3'b010 a constant 0, 3'b011 a constant 1, and 3'b1xx no parity bit. Parity covers only the configured data bits. The parity bit follows the last data bit.
- R3: `mode_word[7:6]` = 2'b10 makes the transmitter send two stop bits. Any other value gives one. The receiver checks only the first stop bit.
- R4: Each transmitted bit lasts exactly 16 `tick16` pulses. `tx_ready` is high only while the transmitter is idle and enabled. The start bit appears on the line in the cycle after the accepting edge. After reset the line idles high.
- R5: The transmitter is enabled only when `ctrl_word[2]` (enable) is 1 and `ctrl_word[3]` (disable) is 0. While it is disabled, `tx_valid` is ignored and the line stays idle.
- R6: A cycle with `ctrl_word[4]` (break start) high and `ctrl_word[5]` (break stop) low forces the transmit line low from the next cycle. The line stays low until a cycle with `ctrl_word[5]` high, which wins if both strobes are high. A character in flight keeps its timing underneath the break.
- R7: The receiver treats a low sample as a possible start bit and checks the line again half a bit later. If the line has gone high by then, it drops the start bit.
- R8: Each received character produces a one-cycle `rx_valid` pulse. `rx_data` and the error flags hold their values until the next character. `rx_par_err` is set when the received parity bit does not match the configured scheme.
- R9: A low first stop bit sets `rx_frm_err` and the character is still delivered. After such a character, the receiver waits for the line to go high before it looks for another start bit. A long break therefore gives exactly one character of value 0 with the framing error set.
- R10: The receiver is enabled only when `ctrl_word[0]` (enable) is 1 and `ctrl_word[1]` (disable) is 0. While it is disabled, it ignores the line and delivers nothing.
- R11: `mode_word[9:8]` routes the lines. In 2'b00 (normal), `txd` carries the transmitter and the receiver reads `rxd`. In 2'b01 (echo), `txd` follows `rxd` and the receiver still reads `rxd`. In 2'b10 (local loopback), the transmitter feeds the receiver and `txd` stays high. In 2'b11 (remote loopback), `txd` follows `rxd` and the receiver delivers nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| mode_word | input | 10 | Length, parity, stop bits and channel mode; bit 0 is unused |
| ctrl_word | input | 6 | RX enable/disable, TX enable/disable, break start/stop |
| tx_valid | input | 1 | A transmit byte is offered |
| tx_data | input | 8 | Transmit byte |
| tx_ready | output | 1 | Transmitter accepts a byte this cycle |
| rx_valid | output | 1 | One-cycle pulse: a character was received |
| rx_data | output | 8 | Received character, zero-filled above the length |
| rx_par_err | output | 1 | Parity mismatch on the character |
| rx_frm_err | output | 1 | First stop bit sampled low |
| rxd | input | 1 | Serial input pin |
| txd | output | 1 | Serial output pin |

## Verification
The bench checks `txd` and `tx_ready` on every clock against a model that expands each accepted byte into a queue of line levels, 16 entries per bit. A bit counter, bit index or state register that goes wrong in the transmitter therefore shows up as a mismatch within one bit time: a bit that is too short or too long, a parity bit in the wrong place, or a stop bit that is missing or extra. Corruption on the receive side shows up at the next `rx_valid` pulse as wrong data or a wrong flag. A start that is lost, rejected by mistake or repeated shows up as a missing or unexpected character by the end of that frame.

// File: rtl/uart_framer_pkg.sv
// Shared types and helpers for the UART character framer.
// Assumes bytes of at most DATA_W bits and a 10-bit mode word.
package uart_framer_pkg;

    localparam int DATA_W = 8;
    localparam int LEN_W  = $clog2(DATA_W + 1);
    localparam int MODE_W = 10;
    localparam int CTRL_W = 6;

    typedef enum logic [1:0] {
        CHAN_NORMAL = 2'b00,
        CHAN_ECHO   = 2'b01,
        CHAN_LOCAL  = 2'b10,
        CHAN_REMOTE = 2'b11
    } chan_mode_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits;      // data bits per character
        logic             par_on;     // a parity bit is present
        logic             par_forced; // parity bit is a constant
        logic             par_sel;    // constant value, or 1 for odd
        logic             two_stop;   // transmitter sends two stop bits
    } frame_cfg_t;

    // Decode the frame format fields of the mode word.
    function automatic frame_cfg_t decode_mode(input logic [MODE_W-1:0] m);
        frame_cfg_t c;
        case (m[2:1])
            2'b10:   c.nbits = LEN_W'(7);
            2'b11:   c.nbits = LEN_W'(6);
            default: c.nbits = LEN_W'(8);
        endcase
        c.par_on     = !m[5];
        c.par_forced = m[4];
        c.par_sel    = m[3];
        c.two_stop   = (m[7:6] == 2'b10);
        return c;
    endfunction

    // Mask that keeps only the configured data bits.
    function automatic logic [DATA_W-1:0] len_mask(input logic [LEN_W-1:0] n);
        return {DATA_W{1'b1}} >> (LEN_W'(DATA_W) - n);
    endfunction

    // Parity bit for masked data under the configured scheme.
    function automatic logic parity_bit(input frame_cfg_t c, input logic [DATA_W-1:0] d);
        return c.par_forced ? c.par_sel : ((^d) ^ c.par_sel);
    endfunction

endpackage

// File: rtl/uart_tx_engine.sv
// Transmit serializer: accepts one byte when idle and enabled and sends
// start, data (LSB first), optional parity and one or two stop bits.
// Assumes cfg stays stable during a frame; each bit lasts OVS ticks.
module uart_tx_engine
    import uart_framer_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              enable,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    output logic              ser_out
);

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);

    typedef enum logic [2:0] {
        TX_IDLE, TX_START, TX_DATA, TX_PAR, TX_STOP1, TX_STOP2
    } tx_state_e;

    tx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  bitidx;
    logic [DATA_W-1:0] shreg;
    logic              par_q;
    logic [DATA_W-1:0] masked;

    // Accept only when no frame is in flight and the path is on.
    assign in_ready = (state == TX_IDLE) && enable;
    assign masked   = in_data & len_mask(cfg.nbits);

    // Frame sequencer: load on accept, advance one bit every OVS ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= TX_IDLE;
            cnt    <= '0;
            bitidx <= '0;
            shreg  <= '0;
            par_q  <= 1'b0;
        end else if (state == TX_IDLE) begin
            if (in_valid && in_ready) begin
                shreg <= masked;
                par_q <= parity_bit(cfg, masked);
                cnt   <= '0;
                state <= TX_START;
            end
        end else if (tick) begin
            if (cnt == LAST) begin
                cnt <= '0;
                case (state)
                    TX_START: begin
                        bitidx <= '0;
                        state  <= TX_DATA;
                    end
                    TX_DATA: begin
                        shreg <= shreg >> 1;
                        if (bitidx == cfg.nbits - LEN_W'(1))
                            state <= cfg.par_on ? TX_PAR : TX_STOP1;
                        else
                            bitidx <= bitidx + LEN_W'(1);
                    end
                    TX_PAR:   state <= TX_STOP1;
                    TX_STOP1: state <= cfg.two_stop ? TX_STOP2 : TX_IDLE;
                    default:  state <= TX_IDLE;
                endcase
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // Line level for the bit currently being sent.
    always_comb begin
        case (state)
            TX_START: ser_out = 1'b0;
            TX_DATA:  ser_out = shreg[0];
            TX_PAR:   ser_out = par_q;
            default:  ser_out = 1'b1;
        endcase
    end

    // R4: an accepted byte puts a start bit on the line in the next cycle.
    assert_start_after_accept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !ser_out)
        else $error("start bit missing after accept");

    // R4: the bit-time counter moves only on ticks.
    assert_count_needs_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != TX_IDLE && !tick) |=> $stable(cnt))
        else $error("bit counter moved without tick");

endmodule

// File: rtl/uart_rx_engine.sv
// Receive deserializer: resynchronises the serial input, confirms start at
// mid-bit, samples each bit mid-cell and reports data with error flags.
// Assumes cfg stays stable during a frame; each bit lasts OVS ticks.
module uart_rx_engine
    import uart_framer_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  frame_cfg_t        cfg,
    input  logic              enable,
    input  logic              ser_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_par_err,
    output logic              out_frm_err
);

    localparam int CNT_W = $clog2(OVS);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(OVS - 1);
    localparam logic [CNT_W-1:0] HALF = CNT_W'(OVS / 2 - 1);

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_HOLD
    } rx_state_e;

    rx_state_e         state;
    logic              sync1, line;
    logic [CNT_W-1:0]  cnt;
    logic [LEN_W-1:0]  bitidx;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] aligned;
    logic              perr_q;
    logic              cfg_unused;

    assign cfg_unused = cfg.two_stop;
    assign aligned    = shreg >> (LEN_W'(DATA_W) - cfg.nbits);

    // Two-stage resynchroniser on the serial input, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            line  <= 1'b1;
        end else begin
            sync1 <= ser_in;
            line  <= sync1;
        end
    end

    // Frame sequencer: hunt, confirm start, sample bits, report, re-arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= RX_IDLE;
            cnt         <= '0;
            bitidx      <= '0;
            shreg       <= '0;
            perr_q      <= 1'b0;
            out_valid   <= 1'b0;
            out_data    <= '0;
            out_par_err <= 1'b0;
            out_frm_err <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (!enable) begin
                state <= RX_IDLE;
            end else begin
                case (state)
                    RX_IDLE: if (tick && !line) begin
                        cnt   <= '0;
                        state <= RX_START;
                    end
                    RX_START: if (tick) begin
                        if (cnt == HALF) begin
                            cnt    <= '0;
                            bitidx <= '0;
                            shreg  <= '0;
                            perr_q <= 1'b0;
                            state  <= line ? RX_IDLE : RX_DATA;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_DATA: if (tick) begin
                        if (cnt == LAST) begin
                            cnt   <= '0;
                            shreg <= {line, shreg[DATA_W-1:1]};
                            if (bitidx == cfg.nbits - LEN_W'(1))
                                state <= cfg.par_on ? RX_PAR : RX_STOP;
                            else
                                bitidx <= bitidx + LEN_W'(1);
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_PAR: if (tick) begin
                        if (cnt == LAST) begin
                            cnt    <= '0;
                            perr_q <= (line != parity_bit(cfg, aligned));
                            state  <= RX_STOP;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    RX_STOP: if (tick) begin
                        if (cnt == LAST) begin
                            cnt         <= '0;
                            out_valid   <= 1'b1;
                            out_data    <= aligned;
                            out_par_err <= perr_q;
                            out_frm_err <= !line;
                            state       <= line ? RX_IDLE : RX_HOLD;
                        end else begin
                            cnt <= cnt + CNT_W'(1);
                        end
                    end
                    default: if (line) state <= RX_IDLE;
                endcase
            end
        end
    end

    // R8: a character is reported by a single-cycle pulse.
    assert_valid_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid)
        else $error("rx valid longer than one cycle");

    // R1: bits above a 6-bit character read as zero.
    assert_zero_fill_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && cfg.nbits == LEN_W'(6)) |-> (out_data[DATA_W-1:6] == '0))
        else $error("upper data bits not zero-filled");

    // R10: a disabled receiver delivers nothing.
    assert_disabled_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> !out_valid)
        else $error("character delivered while disabled");

endmodule

// File: rtl/uart_framer.sv
// UART character framer top: decodes mode and control words, holds the
// break state and routes serial lines per channel mode around the TX and
// RX engines. Assumes tick16 pulses at OVS times the bit rate.
module uart_framer
    import uart_framer_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic [MODE_W-1:0] mode_word,
    input  logic [CTRL_W-1:0] ctrl_word,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_ready,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_par_err,
    output logic              rx_frm_err,
    input  logic              rxd,
    output logic              txd
);

    frame_cfg_t cfg;
    chan_mode_e chan;
    logic       tx_on, rx_on;
    logic       brk_q;
    logic       tx_ser, tx_line, rx_in;
    logic       mode_unused;

    assign cfg         = decode_mode(mode_word);
    assign chan        = chan_mode_e'(mode_word[9:8]);
    assign mode_unused = mode_word[0];
    // A disable bit overrides its enable bit.
    assign tx_on       = ctrl_word[2] && !ctrl_word[3];
    assign rx_on       = ctrl_word[0] && !ctrl_word[1];

    // Break latch: stop strobe clears, start strobe sets.
    always_ff @(posedge clk) begin
        if (!rst_n)            brk_q <= 1'b0;
        else if (ctrl_word[5]) brk_q <= 1'b0;
        else if (ctrl_word[4]) brk_q <= 1'b1;
    end

    assign tx_line = tx_ser && !brk_q;

    // Channel routing between pins and engines.
    always_comb begin
        case (chan)
            CHAN_ECHO:   begin txd = rxd;     rx_in = rxd;     end
            CHAN_LOCAL:  begin txd = 1'b1;    rx_in = tx_line; end
            CHAN_REMOTE: begin txd = rxd;     rx_in = 1'b1;    end
            default:     begin txd = tx_line; rx_in = rxd;     end
        endcase
    end

    uart_tx_engine #(.OVS(OVS)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick16),
        .cfg      (cfg),
        .enable   (tx_on),
        .in_valid (tx_valid),
        .in_data  (tx_data),
        .in_ready (tx_ready),
        .ser_out  (tx_ser)
    );

    uart_rx_engine #(.OVS(OVS)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick16),
        .cfg         (cfg),
        .enable      (rx_on),
        .ser_in      (rx_in),
        .out_valid   (rx_valid),
        .out_data    (rx_data),
        .out_par_err (rx_par_err),
        .out_frm_err (rx_frm_err)
    );

    // R6: a break start in normal mode drives the pin low next cycle.
    assert_break_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_word[4] && !ctrl_word[5] && mode_word[9:8] == 2'b00)
        |=> (mode_word[9:8] != 2'b00 || !txd))
        else $error("break did not pull the line low");

    // R11: local loopback keeps the output pin idle.
    assert_local_pin_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_word[9:8] == 2'b10) |-> txd)
        else $error("txd not idle in local loopback");

endmodule

// File: tb/sim_uart_framer.sv
// Bench: behavioural line model compared with txd/tx_ready every clock,
// plus a queue of expected received characters.
module sim_uart_framer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick16;
    logic [9:0] mode_word;
    logic [5:0] ctrl_word;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready;
    logic       rx_valid;
    logic [7:0] rx_data;
    logic       rx_par_err;
    logic       rx_frm_err;
    logic       rxd;
    logic       txd;

    always #10 clk = ~clk;

    uart_framer u0 (
        .clk(clk), .rst_n(rst_n), .tick16(tick16), .mode_word(mode_word),
        .ctrl_word(ctrl_word), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_par_err(rx_par_err), .rx_frm_err(rx_frm_err), .rxd(rxd), .txd(txd)
    );

    typedef struct { logic [7:0] d; bit pe; bit fe; } rx_exp_t;

    int      vectors = 0;
    int      miscompares = 0;
    bit      done = 0;
    bit      q_tx[$];
    rx_exp_t q_rx[$];
    bit      brk_m = 0;
    string   cur_req = "R4";

    localparam logic [5:0] CTRL_ON = 6'b000101;

    task automatic chk(input string what, input int act, input int exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
        end
    endtask

    function automatic int nbits_of(input logic [9:0] m);
        case (m[2:1])
            2'b10:   return 7;
            2'b11:   return 6;
            default: return 8;
        endcase
    endfunction

    function automatic bit par_of(input logic [9:0] m, input logic [7:0] d, input int n);
        int ones = 0;
        for (int i = 0; i < n; i++) ones += int'(d[i]);
        case (m[4:3])
            2'b00:   return (ones % 2) == 1;
            2'b01:   return (ones % 2) == 0;
            2'b10:   return 1'b0;
            default: return 1'b1;
        endcase
    endfunction

    function automatic int build_frame(input logic [9:0] m, input logic [7:0] d,
                                       input bit flip_par, input bit stop_lvl,
                                       output logic [11:0] fb);
        int n = nbits_of(m);
        int k = 0;
        fb = '1;
        fb[k] = 1'b0; k++;
        for (int i = 0; i < n; i++) begin fb[k] = d[i]; k++; end
        if (!m[5]) begin fb[k] = par_of(m, d, n) ^ flip_par; k++; end
        fb[k] = stop_lvl; k++;
        if (m[7:6] == 2'b10) begin fb[k] = 1'b1; k++; end
        return k;
    endfunction

    task automatic push_frame(input logic [7:0] d);
        logic [11:0] fb;
        int k;
        k = build_frame(mode_word, d, 1'b0, 1'b1, fb);
        for (int i = 0; i < k; i++)
            for (int j = 0; j < 16; j++) q_tx.push_back(fb[i]);
    endtask

    // Per-clock reference comparison, sampled at the falling edge.
    always @(negedge clk) begin
        logic exp_line, exp_pin, exp_rdy;
        rx_exp_t e;
        if (rst_n === 1'b1 && !done) begin
            exp_rdy  = (q_tx.size() == 0) && ctrl_word[2] && !ctrl_word[3];
            exp_line = 1'b1;
            if (q_tx.size() > 0) exp_line = q_tx.pop_front();
            if (brk_m) exp_line = 1'b0;
            case (mode_word[9:8])
                2'b00:        exp_pin = exp_line;
                2'b01, 2'b11: exp_pin = rxd;
                default:      exp_pin = 1'b1;
            endcase
            chk("txd", int'(txd), int'(exp_pin));
            chk("tx_ready", int'(tx_ready), int'(exp_rdy));
            if (tx_valid && tx_ready) push_frame(tx_data);
            if (rx_valid) begin
                if (q_rx.size() == 0) begin
                    chk("unexpected rx char", int'(rx_data), -1);
                end else begin
                    e = q_rx.pop_front();
                    chk("rx_data", int'(rx_data), int'(e.d));
                    chk("rx_par_err", int'(rx_par_err), int'(e.pe));
                    chk("rx_frm_err", int'(rx_frm_err), int'(e.fe));
                end
            end
            if (ctrl_word[5]) brk_m = 1'b0;
            else if (ctrl_word[4]) brk_m = 1'b1;
        end
    end

    task automatic idle(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic tx_send(input logic [7:0] d);
        tx_valid = 1'b1;
        tx_data  = d;
        forever begin
            @(negedge clk);
            if (tx_ready) break;
        end
        @(posedge clk); #1;
        tx_valid = 1'b0;
    endtask

    task automatic wait_tx_done();
        while (q_tx.size() != 0) idle(1);
        idle(4);
    endtask

    task automatic rx_frame(input logic [7:0] d, input bit flip_par, input bit stop_lvl);
        logic [11:0] fb;
        int k;
        k = build_frame(mode_word, d, flip_par, stop_lvl, fb);
        for (int i = 0; i < k; i++) begin
            rxd = fb[i];
            idle(16);
        end
        rxd = 1'b1;
        idle(24);
    endtask

    task automatic expect_rx(input logic [7:0] d, input bit pe, input bit fe);
        rx_exp_t e;
        e.d = d; e.pe = pe; e.fe = fe;
        q_rx.push_back(e);
    endtask

    task automatic drained(input string r);
        cur_req = r;
        chk("rx chars outstanding", q_rx.size(), 0);
    endtask

    task automatic pulse_ctrl(input logic [5:0] bits);
        ctrl_word = CTRL_ON | bits;
        idle(1);
        ctrl_word = CTRL_ON;
    endtask

    initial begin
        rst_n = 1'b0; tick16 = 1'b1; mode_word = 10'h020; ctrl_word = 6'b0;
        tx_valid = 1'b0; tx_data = 8'h00; rxd = 1'b1;
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        cur_req = "R4";
        chk("reset txd", int'(txd), 1);
        chk("reset tx_ready", int'(tx_ready), 0);
        chk("reset rx_valid", int'(rx_valid), 0);
        idle(1);

        // R5: enable and disable both set keeps TX off
        cur_req = "R5";
        ctrl_word = 6'b001100;
        tx_valid = 1'b1; tx_data = 8'h55;
        idle(40);
        tx_valid = 1'b0;
        ctrl_word = CTRL_ON;
        idle(2);

        // R4: 8N1 back-to-back bit timing
        cur_req = "R4";
        tx_send(8'hA5);
        tx_send(8'h3C);
        wait_tx_done();

        // R1, R2: 7-bit even parity, bit 7 ignored
        cur_req = "R1";
        mode_word = 10'h004;
        tx_send(8'hD3);
        wait_tx_done();
        // R2: 6-bit odd, 8-bit mark, 8-bit space
        cur_req = "R2";
        mode_word = 10'h00E; tx_send(8'h2B); wait_tx_done();
        mode_word = 10'h018; tx_send(8'h61); wait_tx_done();
        mode_word = 10'h010; tx_send(8'hF0); wait_tx_done();
        // R3: two stop bits, back-to-back
        cur_req = "R3";
        mode_word = 10'h0A0; tx_send(8'h81); tx_send(8'h7E); wait_tx_done();

        // R8: normal receive 8N1
        cur_req = "R8";
        mode_word = 10'h020;
        expect_rx(8'h5A, 0, 0); rx_frame(8'h5A, 0, 1);
        // R2: 7-bit even parity good then corrupted
        cur_req = "R2";
        mode_word = 10'h004;
        expect_rx(8'h45, 0, 0); rx_frame(8'h45, 0, 1);
        expect_rx(8'h45, 1, 0); rx_frame(8'h45, 1, 1);
        // R1: 6-bit receive zero fill
        cur_req = "R1";
        mode_word = 10'h026;
        expect_rx(8'h35, 0, 0); rx_frame(8'h35, 0, 1);
        // R3: receiver checks only first stop bit with two-stop mode
        cur_req = "R3";
        mode_word = 10'h0A0;
        expect_rx(8'hC9, 0, 0); rx_frame(8'hC9, 0, 1);
        // R9: low stop bit gives framing error, data kept
        cur_req = "R9";
        mode_word = 10'h020;
        expect_rx(8'h33, 0, 1); rx_frame(8'h33, 0, 0);
        drained("R9");

        // R7: short low glitch is not a start bit
        cur_req = "R7";
        rxd = 1'b0; idle(4); rxd = 1'b1; idle(60);
        drained("R7");

        // R10: receiver disabled ignores a frame
        cur_req = "R10";
        ctrl_word = 6'b000111;
        rx_frame(8'h99, 0, 1);
        ctrl_word = CTRL_ON; idle(4);
        drained("R10");

        // R6: break holds line low, frame underneath keeps timing
        cur_req = "R6";
        pulse_ctrl(6'b010000);
        idle(20);
        tx_send(8'hE7);
        idle(60);
        pulse_ctrl(6'b110000);
        wait_tx_done();
        idle(20);

        // R11: automatic echo
        cur_req = "R11";
        mode_word = 10'h120;
        expect_rx(8'h96, 0, 0); rx_frame(8'h96, 0, 1);
        // R11: local loopback
        mode_word = 10'h220; idle(4);
        expect_rx(8'h4E, 0, 0); tx_send(8'h4E); wait_tx_done(); idle(24);
        // R9: long break in loopback gives one zero char with framing error
        cur_req = "R9";
        expect_rx(8'h00, 0, 1);
        pulse_ctrl(6'b010000);
        idle(400);
        pulse_ctrl(6'b100000);
        idle(40);
        drained("R9");
        // R11: remote loopback delivers nothing
        cur_req = "R11";
        mode_word = 10'h320; idle(4);
        rx_frame(8'h77, 0, 1);
        drained("R11");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            miscompares++;
            $display("FAIL %s watchdog: actual timeout expected completion", cur_req);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule